// File: doc/BRIEF.md
# Framed Synchronous Serial Byte Link

This block connects a byte-wide ready/valid source, such as a stream of ADC samples, to a host synchronous serial port. It produces three signals for the host: a bit clock divided down from the system clock, a frame-sync pulse, and serial data. Each frame carries one 8-bit byte, most significant bit first. The frame-sync pulse lasts exactly one bit period and coincides with the first bit. When no byte is waiting, no frame is sent: the sync line and the data line both stay low while the bit clock keeps running.

The returning serial line from the host is captured on the same framing. Both directions share one bit clock and one start event. Outgoing data changes on the falling edge of the bit clock, and incoming data is sampled on the rising edge. The receive shifter begins a byte in the same bit slot in which the transmitter raises frame sync, and it delivers each completed byte as a one-cycle strobe. A one-byte holding register sits in front of the transmit shifter, so that frames can follow one another with no idle bit slot between them.

Top module: `fss_byte_link`

## Requirements
- R1: While `rst_n` is low, `ser_clk`, `ser_fsync`, `ser_dout` and `rx_valid` are 0 and `in_ready` is 1.
- R2: `ser_clk` is periodic with `DIV_RATIO` system cycles per bit. It is low for the first `DIV_RATIO/2` cycles of each bit slot and high for the rest.
- R3: Each frame sends exactly 8 data bits on `ser_dout`, with bit 7 first. `ser_dout` changes only in the cycle in which `ser_clk` falls.
- R4: `ser_fsync` rises together with a falling edge of `ser_clk`. It stays high for exactly one bit slot, the slot that carries bit 7, and it is never high during bits 6 to 0.
- R5: When no byte is held or being shifted, no frame-sync pulse is produced and `ser_dout` is 0. The number of frames sent equals the number of bytes accepted.
- R6: A byte is accepted in a cycle where both `in_valid` and `in_ready` are 1. `in_ready` is 0 in the cycle after an acceptance and stays 0 while the holding register is full. No accepted byte is lost or reordered.
- R7: When a byte is waiting as the last bit of a frame finishes, the next frame-sync pulse comes exactly 8 bit slots after the previous one.
- R8: `ser_din` is sampled at each rising edge of `ser_clk`, starting with the slot in which `ser_fsync` is high, bit 7 first. After the 8th sample, `rx_data` holds the byte and `rx_valid` is high for exactly one cycle.
- R9: `rx_valid` is asserted only for frames that were opened by a frame-sync pulse, so the number of received bytes equals the number of frames sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 8 | Byte to transmit |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Holding register can take a byte |
| rx_data | output | 8 | Last byte received |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| ser_clk | output | 1 | Bit clock to the host, idle low |
| ser_fsync | output | 1 | Frame sync, high during the first bit |
| ser_dout | output | 1 | Serial data to the host |
| ser_din | input | 1 | Serial data from the host |

## Verification
The bench acts as the host. It rebuilds every outgoing byte from `ser_dout` at the rising edges of `ser_clk`, and it answers each frame with a random byte launched on the falling edges. The corner cases it targets are these:
- Back-to-back frames. A design that lets the holding register hand over a slot late would show a 9-slot gap between sync pulses, or would drop a byte.
- Bytes 0x80, 0x01, 0xFF and 0x00. A design that reverses the bit order or shifts one bit too many would corrupt these.
- Long idle gaps. A design that pulses sync with no data would produce extra frames and spurious received bytes.
- A host that drives noise on `ser_din` between frames. A design that opens a receive frame without a sync pulse would raise `rx_valid` outside a frame.

// File: rtl/fss_pkg.sv
package fss_pkg;
    parameter int FSS_WORD_W = 8;
    localparam int FSS_CNT_W = $clog2(FSS_WORD_W + 1);
    typedef logic [FSS_WORD_W-1:0] fss_word_t;
    typedef logic [FSS_CNT_W-1:0]  fss_cnt_t;
endpackage

// File: rtl/fss_bitclk_gen.sv
module fss_bitclk_gen #(
    parameter int DIV_RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ser_clk_o,
    output logic launch_o,
    output logic sample_o
);
    localparam int HALF = DIV_RATIO / 2;
    localparam int CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam logic [CW-1:0] LAST   = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] PRE_HI = CW'(HALF - 1);
    localparam logic [CW-1:0] HI_AT  = CW'(HALF);
    localparam logic [CW-1:0] ONE    = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk;
    } div_state_t;

    div_state_t div_d, div_q;

    always_comb begin
        div_d      = div_q;
        div_d.cnt  = (div_q.cnt == LAST) ? '0 : div_q.cnt + ONE;
        div_d.sclk = (div_d.cnt >= HI_AT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign ser_clk_o = div_q.sclk;
    assign launch_o  = (div_q.cnt == LAST);
    assign sample_o  = (div_q.cnt == PRE_HI);

    AST_RISE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> $past(sample_o)); // R2
endmodule

// File: rtl/fss_tx_framer.sv
module fss_tx_framer
    import fss_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      launch_i,
    input  fss_word_t in_data,
    input  logic      in_valid,
    output logic      in_ready,
    output logic      fsync_o,
    output logic      dout_o
);
    localparam fss_cnt_t ONE  = fss_cnt_t'(1);
    localparam fss_cnt_t FULL = fss_cnt_t'(FSS_WORD_W);

    typedef struct packed {
        fss_word_t sreg;
        fss_cnt_t  bits_left;
        fss_word_t hold;
        logic      hold_vld;
        logic      fsync;
    } tx_state_t;

    tx_state_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (launch_i) begin
            if (tx_q.bits_left > ONE) begin
                tx_d.sreg      = {tx_q.sreg[FSS_WORD_W-2:0], 1'b0};
                tx_d.bits_left = tx_q.bits_left - ONE;
                tx_d.fsync     = 1'b0;
            end else if (tx_q.hold_vld) begin
                tx_d.sreg      = tx_q.hold;
                tx_d.bits_left = FULL;
                tx_d.hold_vld  = 1'b0;
                tx_d.fsync     = 1'b1;
            end else begin
                tx_d.sreg      = '0;
                tx_d.bits_left = '0;
                tx_d.fsync     = 1'b0;
            end
        end
        if (in_valid && !tx_q.hold_vld) begin
            tx_d.hold     = in_data;
            tx_d.hold_vld = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign in_ready = !tx_q.hold_vld;
    assign fsync_o  = tx_q.fsync;
    assign dout_o   = tx_q.sreg[FSS_WORD_W-1];

    AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.hold_vld && !launch_i) |=> (tx_q.hold_vld && $stable(tx_q.hold))); // R6
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.bits_left == '0) |-> (!dout_o && !fsync_o)); // R5
endmodule

// File: rtl/fss_rx_deframer.sv
module fss_rx_deframer
    import fss_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sample_i,
    input  logic      fsync_i,
    input  logic      din_i,
    output fss_word_t rx_data,
    output logic      rx_valid
);
    localparam fss_cnt_t ONE  = fss_cnt_t'(1);
    localparam fss_cnt_t LAST = fss_cnt_t'(FSS_WORD_W - 1);

    typedef struct packed {
        fss_word_t sh;
        fss_cnt_t  cnt;
        fss_word_t data;
        logic      vld;
    } rx_state_t;

    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        if (sample_i) begin
            if (fsync_i) begin
                rx_d.sh  = {{(FSS_WORD_W-1){1'b0}}, din_i};
                rx_d.cnt = ONE;
            end else if (rx_q.cnt != '0) begin
                rx_d.sh = {rx_q.sh[FSS_WORD_W-2:0], din_i};
                if (rx_q.cnt == LAST) begin
                    rx_d.data = {rx_q.sh[FSS_WORD_W-2:0], din_i};
                    rx_d.vld  = 1'b1;
                    rx_d.cnt  = '0;
                end else begin
                    rx_d.cnt = rx_q.cnt + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rx_data  = rx_q.data;
    assign rx_valid = rx_q.vld;

    AST_RX_STROBE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R8
endmodule

// File: rtl/fss_byte_link.sv
module fss_byte_link #(
    parameter int DIV_RATIO = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       ser_clk,
    output logic       ser_fsync,
    output logic       ser_dout,
    input  logic       ser_din
);
    logic launch, sample;

    fss_bitclk_gen #(.DIV_RATIO(DIV_RATIO)) u_clkgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk_o (ser_clk),
        .launch_o  (launch),
        .sample_o  (sample)
    );

    fss_tx_framer u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .fsync_o  (ser_fsync),
        .dout_o   (ser_dout)
    );

    fss_rx_deframer u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .fsync_i  (ser_fsync),
        .din_i    (ser_din),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    AST_DOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dout) |-> $fell(ser_clk)); // R3
    AST_FSYNC_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_fsync) |-> $fell(ser_clk)); // R4
    AST_FSYNC_ENDS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_fsync) |-> $fell(ser_clk)); // R4
endmodule

// File: tb/fss_byte_link_tb.sv
module fss_byte_link_tb;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       ser_clk, ser_fsync, ser_dout;
    logic       ser_din;

    always #4 clk = ~clk;

    fss_byte_link #(.DIV_RATIO(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .rx_data(rx_data), .rx_valid(rx_valid),
        .ser_clk(ser_clk), .ser_fsync(ser_fsync), .ser_dout(ser_dout),
        .ser_din(ser_din)
    );

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];
    int accepted = 0, frames = 0, rx_count = 0;
    int tbits = 0;
    bit stream_on = 0;
    int stream_frames = 0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    function automatic logic [7:0] pop_or_x(ref logic [7:0] q[$]);
        if (q.size() == 0) return 8'hxx;
        return q.pop_front();
    endfunction

    // Host model: rebuilds tx bytes, answers with rx bytes
    initial begin
        int cyc = 0, last_rise = -1, last_fall = -1, rise_idx = 0, last_fs = 0, hbit = -1;
        logic pclk = 1'b0;
        logic [7:0] tacc = '0, hb = '0, e;
        ser_din = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (ser_clk && !pclk) begin
                    if (last_rise >= 0) check(cyc - last_rise == DIV, "R2 period", cyc - last_rise, DIV);
                    if (last_fall >= 0) check(cyc - last_fall == HALF, "R2 low phase", cyc - last_fall, HALF);
                    last_rise = cyc;
                    rise_idx++;
                    if (ser_fsync) begin
                        check(tbits == 0, "R4 sync inside frame", tbits, 0);
                        if (stream_on && stream_frames > 0)
                            check(rise_idx - last_fs == 8, "R7 frame gap", rise_idx - last_fs, 8);
                        if (stream_on) stream_frames++;
                        last_fs = rise_idx;
                        frames++;
                        tacc = {7'b0, ser_dout};
                        tbits = 1;
                    end else if (tbits > 0) begin
                        tacc = {tacc[6:0], ser_dout};
                        tbits++;
                    end else begin
                        check(ser_dout == 1'b0, "R5 idle dout", ser_dout, 0);
                    end
                    if (tbits == 8) begin
                        e = pop_or_x(exp_tx);
                        check(tacc === e, "R3 tx byte", tacc, e);
                        tbits = 0;
                    end
                end
                if (!ser_clk && pclk) begin
                    last_fall = cyc;
                    if (ser_fsync) begin
                        hb = 8'($urandom);
                        exp_rx.push_back(hb);
                        ser_din = hb[7];
                        hbit = 6;
                    end else if (hbit >= 0) begin
                        ser_din = hb[hbit];
                        hbit--;
                    end else begin
                        ser_din = 1'($urandom);
                    end
                end
                if (rx_valid) begin
                    rx_count++;
                    e = pop_or_x(exp_rx);
                    check(rx_data === e, "R8 rx byte", rx_data, e);
                end
                pclk = ser_clk;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        logic r;
        in_data = b;
        in_valid = 1'b1;
        forever begin
            r = in_ready;
            @(negedge clk);
            if (r) break;
        end
        exp_tx.push_back(b);
        accepted++;
        check(in_ready == 1'b0, "R6 ready after accept", in_ready, 0);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_tx.size() != 0 || tbits != 0) @(negedge clk);
        repeat (4 * DIV) @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(ser_clk == 0 && ser_fsync == 0 && ser_dout == 0, "R1 serial outs", {ser_clk, ser_fsync, ser_dout}, 0);
        check(in_ready == 1 && rx_valid == 0, "R1 ready/valid", {in_ready, rx_valid}, 2);
        rst_n = 1'b1;
        repeat (60) @(negedge clk);
        check(frames == 0 && rx_count == 0, "R5 no idle frames", frames, 0);

        // directed single bytes
        send_byte(8'h80); drain();
        send_byte(8'h01); drain();

        // back-to-back stream
        stream_on = 1; stream_frames = 0;
        send_byte(8'hFF); send_byte(8'h00); send_byte(8'hA5);
        send_byte(8'h5A); send_byte(8'h3C); send_byte(8'hC3);
        drain();
        stream_on = 0;
        check(stream_frames == 6, "R7 stream frames", stream_frames, 6);

        // random bytes with random gaps
        for (int i = 0; i < 60; i++) begin
            send_byte(8'($urandom));
            repeat ($urandom_range(0, 60)) @(negedge clk);
        end
        drain();
        repeat (60) @(negedge clk);

        check(frames == accepted, "R5 frames vs bytes", frames, accepted);
        check(rx_count == frames, "R9 rx count", rx_count, frames);
        check(exp_rx.size() == 0, "R9 rx leftover", exp_rx.size(), 0);
        finish_run();
    end
endmodule